// File: doc/BRIEF.md
# Debug Break Trigger Pin Controller

This block sits between the debug port pins of a processor and its core. It owns two shared pins. The first is a single input that does two jobs. While the active-low debug reset is held, its level is a reset-mode strap that decides whether the core is reset. Once debug reset is released, it becomes the serial data input of the debug shifter. The second is a bidirectional break pin, whose direction is chosen by a select input.

When the break pin is an input, a falling edge on its synchronized level raises a break request towards the core. That request is held until the core signals its return to normal mode. When the break pin is an output, hardware breakpoint strobes from the core produce one low trigger pulse. Later events are folded into that trigger. While the core is in debug mode, the pin is held low and any unreported events are dropped.

The block also tracks the debug-mode state. The core enters debug mode by acknowledging a break and leaves it with a return strobe.

Top module: `brkpin_ctrl`

## Requirements
- R1: While `dbg_rst_n` is 0, `ser_data` is 0 and `core_rst_req` is the inverse of `strap_data_in`: strap 0 requests a core reset, strap 1 does not. While `dbg_rst_n` is 1, `ser_data` equals `strap_data_in` and `core_rst_req` is 0. Both outputs are combinational.
- R2: `brk_pin_oe` is 1 exactly when `pin_dir_out` is 1 (1 means output) and `dbg_rst_n` is 1.
- R3: With `pin_dir_out` = 0 and `dbg_rst_n` = 1, a 1-to-0 change of `brk_pin_in` raises `brk_req` after the third rising clock edge following the change (two synchronizer stages plus one register).
- R4: Once raised, `brk_req` stays 1, in debug mode or not, until a clock edge that samples `core_return` = 1, after which it is 0. When `core_return` and a new falling edge are sampled together, the return wins.
- R5: Falling edges on `brk_pin_in` are ignored while `pin_dir_out` = 1 or while `dbg_rst_n` = 0, and `brk_req` stays 0.
- R6: `dbg_mode` becomes 1 after an edge that samples `core_brk_ack` = 1 and becomes 0 after an edge that samples `core_return` = 1. The return wins when both are sampled together.
- R7: With `pin_dir_out` = 1, `dbg_rst_n` = 1 and `dbg_mode` = 0, a sampled `ev_iaddr` or `ev_daccess` strobe drives `brk_pin_out` low for exactly one cycle, the cycle after that edge. Otherwise the pin is high in normal mode.
- R8: Events sampled after a trigger has been issued, and before the next `core_return`, produce no further pulse.
- R9: While `dbg_mode` = 1, `brk_pin_out` is 0. Events sampled in debug mode are discarded and produce no pulse after the return. The first event after the return produces a new pulse.
- R10: An edge that samples `dbg_rst_n` = 0 clears `dbg_mode`, `brk_req` and the event-merge state.
- R11: After `rst_n` reset, `brk_req` = 0, `dbg_mode` = 0 and `brk_pin_out` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous block reset |
| dbg_rst_n | input | 1 | Active-low debug reset |
| pin_dir_out | input | 1 | Break pin direction, 1 = output |
| brk_pin_in | input | 1 | Raw level read from the break pin |
| strap_data_in | input | 1 | Shared strap / serial data input |
| ev_iaddr | input | 1 | Instruction-address breakpoint strobe |
| ev_daccess | input | 1 | Data-access breakpoint strobe |
| core_brk_ack | input | 1 | Core has entered the break |
| core_return | input | 1 | Core returns to normal mode |
| brk_pin_out | output | 1 | Level driven onto the break pin |
| brk_pin_oe | output | 1 | Output enable for the break pin |
| brk_req | output | 1 | Held break request to the core |
| dbg_mode | output | 1 | Core is in debug mode |
| core_rst_req | output | 1 | Debug reset is valid, so reset the core |
| ser_data | output | 1 | Serial data to the debug shifter |

## Verification
The strap decision, serial data routing and output enable are due in the same cycle as their inputs. The break request appears three edges after the pin falls. Debug mode and the trigger pulse change one edge after the sampled strobe. The bench drives inputs 1 ns after a rising edge and compares every output with a behavioural model at the falling edge, so each result is read in the cycle it is due. Directed checks count edges explicitly, which proves the request is absent after two edges and present after three, and that the pulse lasts a single cycle.

// File: rtl/brkpin_pkg.sv
package brkpin_pkg;
  localparam int SYNC_STAGES = 2;

  // any breakpoint strobe counts as one event
  function automatic logic any_event(input logic ia, input logic da);
    return ia | da;
  endfunction

  // falling edge between an older and a newer sample
  function automatic logic is_fall(input logic older, input logic newer);
    return older & ~newer;
  endfunction
endpackage

// File: rtl/brkpin_sync.sv
module brkpin_sync #(
  parameter int STAGES = brkpin_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign dout = chain[STAGES-1];
  assign fall = brkpin_pkg::is_fall(prev, dout);
endmodule

// File: rtl/brkpin_req.sv
module brkpin_req (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_rst_n,
  input  logic fall,
  input  logic dir_out,
  input  logic ack,
  input  logic ret,
  output logic pend,
  output logic mode
);
  logic take;
  assign take = fall & ~dir_out & dbg_rst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= 1'b0;
      mode <= 1'b0;
    end else if (!dbg_rst_n || ret) begin
      pend <= 1'b0;
      mode <= 1'b0;
    end else begin
      if (take) pend <= 1'b1;
      if (ack)  mode <= 1'b1;
    end
  end
endmodule

// File: rtl/brkpin_trig.sv
module brkpin_trig (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_rst_n,
  input  logic hit,
  input  logic dir_out,
  input  logic mode,
  input  logic ret,
  output logic pulse,
  output logic merged
);
  logic fire;
  assign fire = hit & dir_out & dbg_rst_n & ~mode & ~merged;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulse  <= 1'b0;
      merged <= 1'b0;
    end else begin
      pulse <= fire;
      if (!dbg_rst_n || ret) merged <= 1'b0;
      else if (fire)         merged <= 1'b1;
    end
  end
endmodule

// File: rtl/brkpin_ctrl.sv
module brkpin_ctrl #(
  parameter int STAGES = brkpin_pkg::SYNC_STAGES
) (
  input  logic clk,
  input  logic rst_n,
  input  logic dbg_rst_n,
  input  logic pin_dir_out,
  input  logic brk_pin_in,
  input  logic strap_data_in,
  input  logic ev_iaddr,
  input  logic ev_daccess,
  input  logic core_brk_ack,
  input  logic core_return,
  output logic brk_pin_out,
  output logic brk_pin_oe,
  output logic brk_req,
  output logic dbg_mode,
  output logic core_rst_req,
  output logic ser_data
);
  logic pin_sync;
  logic fall_evt;
  logic hit_evt;
  logic trig_pulse;
  logic merged;

  brkpin_sync #(.STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(brk_pin_in), .dout(pin_sync), .fall(fall_evt)
  );

  brkpin_req u_req (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .fall(fall_evt),
    .dir_out(pin_dir_out), .ack(core_brk_ack), .ret(core_return),
    .pend(brk_req), .mode(dbg_mode)
  );

  assign hit_evt = brkpin_pkg::any_event(ev_iaddr, ev_daccess);

  brkpin_trig u_trig (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .hit(hit_evt),
    .dir_out(pin_dir_out), .mode(dbg_mode), .ret(core_return),
    .pulse(trig_pulse), .merged(merged)
  );

  assign brk_pin_out  = ~(trig_pulse | dbg_mode);
  assign brk_pin_oe   = pin_dir_out & dbg_rst_n;
  assign core_rst_req = ~dbg_rst_n & ~strap_data_in;
  assign ser_data     = dbg_rst_n & strap_data_in;

  logic unused_sync;
  assign unused_sync = pin_sync;
endmodule

// File: rtl/brkpin_ctrl_chk.sv
module brkpin_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic dbg_rst_n,
  input logic strap_data_in,
  input logic core_return,
  input logic core_brk_ack,
  input logic brk_pin_out,
  input logic brk_pin_oe,
  input logic brk_req,
  input logic dbg_mode,
  input logic core_rst_req,
  input logic trig_pulse,
  input logic merged
);
  assert_strap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rst_n |-> (core_rst_req == !strap_data_in));

  assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rst_n |-> !brk_pin_oe);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (brk_req && !core_return && dbg_rst_n) |=> brk_req);

  assert_return_R6: assert property (@(posedge clk) disable iff (!rst_n)
    core_return |=> !dbg_mode);

  assert_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (core_brk_ack && !core_return && dbg_rst_n) |=> dbg_mode);

  assert_one_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pulse |=> !trig_pulse);

  assert_fold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trig_pulse) |-> $past(!merged));

  assert_low_in_dbg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_mode |-> !brk_pin_out);

  assert_dbg_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !dbg_rst_n |=> (!dbg_mode && !brk_req && !merged));
endmodule

bind brkpin_ctrl brkpin_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .strap_data_in(strap_data_in),
  .core_return(core_return), .core_brk_ack(core_brk_ack),
  .brk_pin_out(brk_pin_out), .brk_pin_oe(brk_pin_oe), .brk_req(brk_req),
  .dbg_mode(dbg_mode), .core_rst_req(core_rst_req),
  .trig_pulse(trig_pulse), .merged(merged)
);

// File: tb/test_brkpin_ctrl.sv
`timescale 1ns/1ps
module test_brkpin_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0, dbg_rst_n = 1'b1, pin_dir_out = 1'b0, brk_pin_in = 1'b1;
  logic strap_data_in = 1'b1, ev_iaddr = 1'b0, ev_daccess = 1'b0;
  logic core_brk_ack = 1'b0, core_return = 1'b0;
  logic brk_pin_out, brk_pin_oe, brk_req, dbg_mode, core_rst_req, ser_data;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  brkpin_ctrl i_brkpin_ctrl (
    .clk(clk), .rst_n(rst_n), .dbg_rst_n(dbg_rst_n), .pin_dir_out(pin_dir_out),
    .brk_pin_in(brk_pin_in), .strap_data_in(strap_data_in), .ev_iaddr(ev_iaddr),
    .ev_daccess(ev_daccess), .core_brk_ack(core_brk_ack), .core_return(core_return),
    .brk_pin_out(brk_pin_out), .brk_pin_oe(brk_pin_oe), .brk_req(brk_req),
    .dbg_mode(dbg_mode), .core_rst_req(core_rst_req), .ser_data(ser_data)
  );

  // behavioural reference model
  bit hist[$] = '{1'b1, 1'b1, 1'b1};
  bit m_req = 0, m_mode = 0, m_pulse = 0, m_seen = 0;

  always @(posedge clk) begin
    bit fell, ok_ev;
    if (!rst_n) begin
      hist = '{1'b1, 1'b1, 1'b1};
      m_req = 0; m_mode = 0; m_pulse = 0; m_seen = 0;
    end else begin
      fell  = hist[2] && !hist[1];
      ok_ev = (ev_iaddr || ev_daccess) && pin_dir_out && dbg_rst_n && !m_mode && !m_seen;
      m_pulse = ok_ev;
      if (!dbg_rst_n || core_return) begin
        m_req = 0; m_mode = 0; m_seen = 0;
      end else begin
        if (fell && !pin_dir_out) m_req = 1;
        if (core_brk_ack) m_mode = 1;
        if (ok_ev) m_seen = 1;
      end
      hist.push_front(brk_pin_in);
      void'(hist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk("R1 ser_data", ser_data, dbg_rst_n ? strap_data_in : 1'b0);
      chk("R1 core_rst_req", core_rst_req, !dbg_rst_n && !strap_data_in);
      chk("R2 brk_pin_oe", brk_pin_oe, pin_dir_out && dbg_rst_n);
      chk("R3 brk_req", brk_req, m_req);
      chk("R6 dbg_mode", dbg_mode, m_mode);
      chk("R7 brk_pin_out", brk_pin_out, !(m_pulse || m_mode));
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic look;
    @(negedge clk);
  endtask

  task automatic strobe_ret;
    core_return = 1; step(1); core_return = 0;
  endtask

  initial begin
    step(3);
    rst_n = 1;
    look;
    chk("R11 brk_req", brk_req, 1'b0);
    chk("R11 dbg_mode", dbg_mode, 1'b0);
    chk("R11 brk_pin_out", brk_pin_out, 1'b1);

    // R1 strap during debug reset
    step(1); dbg_rst_n = 0; strap_data_in = 0; #0.5;
    chk("R1 strap0", core_rst_req, 1'b1);
    chk("R1 ser0", ser_data, 1'b0);
    strap_data_in = 1; #0.5;
    chk("R1 strap1", core_rst_req, 1'b0);
    // R5 fall during debug reset is ignored
    brk_pin_in = 0; step(5);
    look; chk("R5 dbg reset fall", brk_req, 1'b0);
    step(1); dbg_rst_n = 1; brk_pin_in = 1; step(4);

    // R3 latency in input mode
    brk_pin_in = 0;
    repeat (2) @(posedge clk);
    look; chk("R3 not yet", brk_req, 1'b0);
    look; chk("R3 raised", brk_req, 1'b1);
    step(1); brk_pin_in = 1;

    // R4 hold through debug mode
    core_brk_ack = 1; step(1); core_brk_ack = 0;
    look; chk("R6 entered", dbg_mode, 1'b1);
    step(1); brk_pin_in = 0; step(4); brk_pin_in = 1; step(4);
    look; chk("R4 held", brk_req, 1'b1);
    step(1); strobe_ret;
    look; chk("R4 cleared", brk_req, 1'b0);
    chk("R6 left", dbg_mode, 1'b0);

    // R5 output mode ignores falls
    step(1); pin_dir_out = 1; brk_pin_in = 0; step(5);
    look; chk("R5 output mode fall", brk_req, 1'b0);
    step(1); brk_pin_in = 1; step(3);

    // R7 single pulse, R8 folding
    ev_iaddr = 1; step(1); ev_iaddr = 0;
    look; chk("R7 pulse low", brk_pin_out, 1'b0);
    look; chk("R7 pulse ends", brk_pin_out, 1'b1);
    step(1); ev_daccess = 1; step(1); ev_daccess = 0;
    look; chk("R8 folded", brk_pin_out, 1'b1);

    // R9 debug mode holds low, discards events
    step(1); core_brk_ack = 1; step(1); core_brk_ack = 0;
    ev_daccess = 1; step(2); ev_daccess = 0;
    look; chk("R9 held low", brk_pin_out, 1'b0);
    step(1); strobe_ret;
    look; chk("R9 no late pulse", brk_pin_out, 1'b1);
    step(1); ev_iaddr = 1; step(1); ev_iaddr = 0;
    look; chk("R9 new pulse", brk_pin_out, 1'b0);

    // R4/R6 return wins over simultaneous ack and fall
    step(1); pin_dir_out = 0; core_brk_ack = 1; core_return = 1; step(1);
    core_brk_ack = 0; core_return = 0;
    look; chk("R6 return wins", dbg_mode, 1'b0);

    // R10 debug reset clears state
    step(1); brk_pin_in = 0; core_brk_ack = 1; step(1); core_brk_ack = 0; step(4);
    look; chk("R10 pre req", brk_req, 1'b1);
    step(1); dbg_rst_n = 0; step(1);
    look; chk("R10 req cleared", brk_req, 1'b0);
    chk("R10 mode cleared", dbg_mode, 1'b0);
    step(1); dbg_rst_n = 1; brk_pin_in = 1; pin_dir_out = 1; step(3);
    ev_iaddr = 1; step(1); ev_iaddr = 0;
    look; chk("R10 merge cleared", brk_pin_out, 1'b0);

    step(4);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      finished = 1;
      bad++; total++;
      $display("FAIL watchdog R11 actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule